// File: doc/BRIEF.md
# Sleep and Clock-Output Pin Controller

This block interprets a single asynchronous, multipurpose control pin according to the radio's current base state. The pin passes through a synchroniser, and the block then detects its edges. It uses them to do one of three things: request entry into or exit from the low-power doze state, request a receive state with the output clock silenced, or fire a transmit-start pulse. In some states a rising edge alone triggers an action. In others the pin works as a level hold, so its falling edge undoes the earlier request.

The block also owns the enable of the output clock that feeds a host. Entering the doze state or a silenced receive state does not cut that clock at once. The block first lets a fixed number of output-clock periods run, counted by an internal divider whose period follows the rate select. At the two slowest rates the clock is cut at once. While the radio is in a silenced receive state, a receive-start event turns the clock back on.

State encoding (4 bits): 0 idle, 1 doze, 2 listen, 3 listen-quiet, 4 auto-ack listen, 5 auto-ack quiet, 6 ready, 7 retry-transmit, 8 to 15 other. Rate select (3 bits): codes 0 to 5 give an output-clock period of 2^code system cycles; codes 6 and 7 are the slow rates.

Top module: `sleep_pin_ctrl`

## Requirements
- R1: In state 6 or 7, a rising pin edge produces a one-cycle `tx_start` pulse, visible after the third rising clock edge following the pin change.
- R2: In state 0, a rising pin edge requests state 1. In state 1, a falling pin edge requests state 0. Each request is a one-cycle `req_valid` with `req_state`, and has the same latency as R1.
- R3: In state 2, a rising edge requests 3, and in state 3 a falling edge requests 2. States 4 and 5 behave the same way with each other.
- R4: With rate code 0 to 5, once the current state is 1, 3 or 5, `clkout_en` stays high for 35 output-clock periods and then drops. At code 0 it is still high 35 cycles after the state change and low after 36.
- R5: With rate code 6 or 7, `clkout_en` is low one cycle after the state becomes 1, 3 or 5.
- R6: In state 3 or 5, a `rx_start` pulse raises `clkout_en` in the following cycle, and it stays high while the state is unchanged. In state 1, `rx_start` has no effect.
- R7: Edges of the wrong direction, and all edges in states 8 to 15, produce no request and no pulse.
- R8: After reset, `req_valid` and `tx_start` are 0 and `clkout_en` is 1.
- R9: Leaving states 1, 3 and 5 sets `clkout_en` high in the next cycle, including in the middle of the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Asynchronous multipurpose control pin |
| cur_state | input | 4 | Current radio base state |
| rate_sel | input | 3 | Output-clock rate code |
| rx_start | input | 1 | Receive-start event, one cycle |
| req_valid | output | 1 | State-change request strobe |
| req_state | output | 4 | Requested next state |
| tx_start | output | 1 | Transmit-start pulse |
| clkout_en | output | 1 | Output-clock enable |

## Verification
If the edge detector or the decoder holds a wrong value, the fault shows three cycles after a pin change. It appears as a missing, doubled or misdirected request or pulse on the strobes. A wrong countdown or gate state shows at `clkout_en` as an early or late drop, measured against an exact cycle count at the fastest rate and a two-cycle window at the next rate. A stale wake flag shows as a clock that stays high or low when the state is entered again.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int STATE_W = 4;
  localparam int RATE_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE        = 4'd0,
    ST_DOZE        = 4'd1,
    ST_LISTEN      = 4'd2,
    ST_LISTEN_Q    = 4'd3,
    ST_AUTOACK     = 4'd4,
    ST_AUTOACK_Q   = 4'd5,
    ST_READY       = 4'd6,
    ST_RETRY_TX    = 4'd7
  } radio_state_e;

  typedef enum logic [1:0] {
    GATE_RUN   = 2'd0,
    GATE_DRAIN = 2'd1,
    GATE_STOP  = 2'd2
  } gate_state_e;

  localparam logic [RATE_W-1:0] RATE_SLOW_A = 3'd6;
  localparam logic [RATE_W-1:0] RATE_SLOW_B = 3'd7;
endpackage

// File: rtl/spc_sync_edge.sv
module spc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN-2:0], din};
    end
  end

  assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  assign fall = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
endmodule

// File: rtl/spc_pin_decoder.sv
module spc_pin_decoder
  import spc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise,
  input  logic               fall,
  input  logic [STATE_W-1:0] cur_state,
  output logic               req_valid,
  output logic [STATE_W-1:0] req_state,
  output logic               tx_start
);
  logic               req_valid_d;
  logic [STATE_W-1:0] req_state_d;
  logic               tx_start_d;

  always_comb begin
    req_valid_d = 1'b0;
    req_state_d = '0;
    tx_start_d  = 1'b0;
    case (cur_state)
      ST_READY, ST_RETRY_TX: tx_start_d = rise;
      ST_IDLE: begin
        req_valid_d = rise;
        req_state_d = ST_DOZE;
      end
      ST_DOZE: begin
        req_valid_d = fall;
        req_state_d = ST_IDLE;
      end
      ST_LISTEN: begin
        req_valid_d = rise;
        req_state_d = ST_LISTEN_Q;
      end
      ST_LISTEN_Q: begin
        req_valid_d = fall;
        req_state_d = ST_LISTEN;
      end
      ST_AUTOACK: begin
        req_valid_d = rise;
        req_state_d = ST_AUTOACK_Q;
      end
      ST_AUTOACK_Q: begin
        req_valid_d = fall;
        req_state_d = ST_AUTOACK;
      end
      default: begin
        req_valid_d = 1'b0;
      end
    endcase
    if (!req_valid_d) req_state_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_state <= '0;
      tx_start  <= 1'b0;
    end else begin
      req_valid <= req_valid_d;
      req_state <= req_state_d;
      tx_start  <= tx_start_d;
    end
  end
endmodule

// File: rtl/spc_clk_gate.sv
module spc_clk_gate
  import spc_pkg::*;
#(
  parameter int HOLD_TICKS = 35,
  parameter int MAX_CODE   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               rx_start,
  output logic               clkout_en
);
  localparam int DIV_W = (MAX_CODE < 1) ? 1 : MAX_CODE;
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_TICKS);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_mask;
  logic             tick;
  logic             slow;
  logic             quiet_st;
  logic             doze_st;
  logic             woken_q, woken_d;
  logic             hold_off;
  gate_state_e      gate_q, gate_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // free-running divider defining the output-clock period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    div_mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(rate_sel)) div_mask[i] = 1'b1;
    end
    tick = ((div_q & div_mask) == div_mask);
  end

  assign slow     = (rate_sel == RATE_SLOW_A) || (rate_sel == RATE_SLOW_B);
  assign quiet_st = (cur_state == ST_LISTEN_Q) || (cur_state == ST_AUTOACK_Q);
  assign doze_st  = (cur_state == ST_DOZE);
  assign woken_d  = quiet_st & (woken_q | rx_start);
  assign hold_off = doze_st | (quiet_st & ~woken_q & ~rx_start);

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    case (gate_q)
      GATE_RUN: begin
        if (hold_off) begin
          if (slow) begin
            gate_d = GATE_STOP;
          end else begin
            gate_d = GATE_DRAIN;
            cnt_d  = HOLD_LOAD;
          end
        end
      end
      GATE_DRAIN: begin
        if (!hold_off) begin
          gate_d = GATE_RUN;
        end else if (slow) begin
          gate_d = GATE_STOP;
        end else if (tick) begin
          if (cnt_q <= CNT_W'(1)) gate_d = GATE_STOP;
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (!hold_off) gate_d = GATE_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= GATE_RUN;
      cnt_q   <= '0;
      woken_q <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      cnt_q   <= cnt_d;
      woken_q <= woken_d;
    end
  end

  assign clkout_en = (gate_q != GATE_STOP);
endmodule

// File: rtl/sleep_pin_ctrl.sv
module sleep_pin_ctrl
  import spc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 35,
  parameter int MAX_CODE    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_pin,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               rx_start,
  output logic               req_valid,
  output logic [STATE_W-1:0] req_state,
  output logic               tx_start,
  output logic               clkout_en
);
  logic pin_rise;
  logic pin_fall;

  spc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ctl_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  spc_pin_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (pin_rise),
    .fall     (pin_fall),
    .cur_state(cur_state),
    .req_valid(req_valid),
    .req_state(req_state),
    .tx_start (tx_start)
  );

  spc_clk_gate #(.HOLD_TICKS(HOLD_TICKS), .MAX_CODE(MAX_CODE)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_state(cur_state),
    .rate_sel (rate_sel),
    .rx_start (rx_start),
    .clkout_en(clkout_en)
  );
endmodule

// File: rtl/sleep_pin_ctrl_chk.sv
module sleep_pin_ctrl_chk
  import spc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] cur_state,
  input logic [RATE_W-1:0]  rate_sel,
  input logic               rx_start,
  input logic               req_valid,
  input logic [STATE_W-1:0] req_state,
  input logic               tx_start,
  input logic               clkout_en
);
  logic in_quiet;
  logic in_off;
  logic slow;
  assign in_quiet = (cur_state == ST_LISTEN_Q) || (cur_state == ST_AUTOACK_Q);
  assign in_off   = in_quiet || (cur_state == ST_DOZE);
  assign slow     = (rate_sel == RATE_SLOW_A) || (rate_sel == RATE_SLOW_B);

  assert_tx_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_tx_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(cur_state) == ST_READY || $past(cur_state) == ST_RETRY_TX));

  assert_doze_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_state == ST_DOZE) |-> $past(cur_state) == ST_IDLE);

  assert_quiet_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_state == ST_LISTEN_Q) |-> $past(cur_state) == ST_LISTEN);

  assert_other_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(cur_state) <= ST_AUTOACK_Q));

  assert_drop_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkout_en) |-> $past(in_off));

  assert_slow_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && cur_state == ST_DOZE) |=> !clkout_en);

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && in_quiet) |=> clkout_en);

  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_off |=> clkout_en);
endmodule

bind sleep_pin_ctrl sleep_pin_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur_state(cur_state),
  .rate_sel (rate_sel),
  .rx_start (rx_start),
  .req_valid(req_valid),
  .req_state(req_state),
  .tx_start (tx_start),
  .clkout_en(clkout_en)
);

// File: tb/test_sleep_pin_ctrl.sv
module test_sleep_pin_ctrl;
  logic       clk;
  logic       rst_n;
  logic       ctl_pin;
  logic [3:0] cur_state;
  logic [2:0] rate_sel;
  logic       rx_start;
  logic       req_valid;
  logic [3:0] req_state;
  logic       tx_start;
  logic       clkout_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sleep_pin_ctrl i_sleep_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .cur_state(cur_state),
    .rate_sel(rate_sel), .rx_start(rx_start), .req_valid(req_valid),
    .req_state(req_state), .tx_start(tx_start), .clkout_en(clkout_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {valid, state[3:0], tx} from requirements R1, R2, R3, R7
  function automatic logic [5:0] expect_out(input logic [3:0] st, input logic r, input logic f);
    case (st)
      4'd6, 4'd7: return {1'b0, 4'd0, r};
      4'd0: return r ? {1'b1, 4'd1, 1'b0} : 6'd0;
      4'd1: return f ? {1'b1, 4'd0, 1'b0} : 6'd0;
      4'd2: return r ? {1'b1, 4'd3, 1'b0} : 6'd0;
      4'd3: return f ? {1'b1, 4'd2, 1'b0} : 6'd0;
      4'd4: return r ? {1'b1, 4'd5, 1'b0} : 6'd0;
      4'd5: return f ? {1'b1, 4'd4, 1'b0} : 6'd0;
      default: return 6'd0;
    endcase
  endfunction

  task automatic pin_case(input string tag, input logic [3:0] st, input logic p0, input logic p1);
    logic [5:0] e;
    cur_state = st;
    ctl_pin   = p0;
    step(5);
    ctl_pin = p1;
    step(2);
    check({tag, " early"}, {req_valid, tx_start}, 0);
    step(1);
    e = expect_out(st, p1 & ~p0, p0 & ~p1);
    check(tag, {req_valid, req_state, tx_start}, e);
    step(1);
    check({tag, " one-cycle"}, {req_valid, tx_start}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd4321);
    rst_n = 1'b0; ctl_pin = 1'b0; cur_state = 4'd8; rate_sel = 3'd0; rx_start = 1'b0;
    step(3);
    check("R8 req_valid reset", req_valid, 0);
    check("R8 tx_start reset", tx_start, 0);
    check("R8 clkout_en reset", clkout_en, 1);
    rst_n = 1'b1;
    step(2);

    // directed edges
    pin_case("R1 ready rise", 4'd6, 1'b0, 1'b1);
    pin_case("R1 retry rise", 4'd7, 1'b0, 1'b1);
    pin_case("R7 ready fall", 4'd6, 1'b1, 1'b0);
    pin_case("R2 idle rise", 4'd0, 1'b0, 1'b1);
    pin_case("R2 doze fall", 4'd1, 1'b1, 1'b0);
    pin_case("R7 doze rise", 4'd1, 1'b0, 1'b1);
    pin_case("R3 listen rise", 4'd2, 1'b0, 1'b1);
    pin_case("R3 listen quiet fall", 4'd3, 1'b1, 1'b0);
    pin_case("R3 autoack rise", 4'd4, 1'b0, 1'b1);
    pin_case("R3 autoack quiet fall", 4'd5, 1'b1, 1'b0);
    pin_case("R7 other state rise", 4'd11, 1'b0, 1'b1);

    // random edge patterns
    for (int i = 0; i < 300; i++) begin
      logic [3:0] st;
      logic a, b;
      st = 4'($urandom_range(0, 10));
      a  = 1'($urandom_range(0, 1));
      b  = 1'($urandom_range(0, 1));
      pin_case("R7 random", st, a, b);
    end
    ctl_pin = 1'b0;
    cur_state = 4'd2;
    rate_sel = 3'd0;
    step(6);

    // R4 exact drain at code 0
    cur_state = 4'd1;
    step(35);
    check("R4 code0 still on", clkout_en, 1);
    step(1);
    check("R4 code0 off", clkout_en, 0);
    cur_state = 4'd0;
    step(1);
    check("R9 resume", clkout_en, 1);

    // R4 drain at code 1
    rate_sel = 3'd1;
    cur_state = 4'd3;
    step(68);
    check("R4 code1 still on", clkout_en, 1);
    step(4);
    check("R4 code1 off", clkout_en, 0);
    cur_state = 4'd2;
    step(1);
    check("R9 resume code1", clkout_en, 1);

    // R5 slow codes
    rate_sel = 3'd6;
    cur_state = 4'd1;
    step(1);
    check("R5 code6 immediate", clkout_en, 0);
    cur_state = 4'd0;
    step(2);
    rate_sel = 3'd7;
    cur_state = 4'd5;
    step(1);
    check("R5 code7 immediate", clkout_en, 0);
    cur_state = 4'd4;
    step(2);

    // R9 mid-drain exit
    rate_sel = 3'd0;
    cur_state = 4'd1;
    step(10);
    cur_state = 4'd2;
    step(1);
    check("R9 mid-drain", clkout_en, 1);
    step(40);
    check("R9 stays on", clkout_en, 1);

    // R6 wake in quiet state
    cur_state = 4'd3;
    step(40);
    check("R6 quiet off", clkout_en, 0);
    rx_start = 1'b1;
    step(1);
    rx_start = 1'b0;
    check("R6 wake", clkout_en, 1);
    step(50);
    check("R6 wake held", clkout_en, 1);
    cur_state = 4'd2;
    step(2);
    cur_state = 4'd1;
    step(40);
    rx_start = 1'b1;
    step(1);
    rx_start = 1'b0;
    check("R6 doze ignores rx_start", clkout_en, 0);
    step(5);
    check("R6 doze still off", clkout_en, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule